// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Core

This block is a small 32-bit processor with sixteen general registers and two private memories: one holds the program, the other holds data. Each instruction passes through five stages: fetch, decode with register read, execute with branch resolution, memory access, and write-back. Adjacent stages never update on the same clock edge. A phase bit toggles every cycle. Fetch, execute and write-back move on one value of the bit, and decode and memory move on the other. A new instruction therefore enters the pipe every second clock.

There is no forwarding, no interlock and no prediction. The program itself must space dependent instructions apart with filler instructions. Both memories are filled through a preload port while reset is held. When a halt instruction reaches write-back, the core raises a completion flag and freezes. A registered debug port lets the surrounding logic read any register.

Top module: `pipe_core`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, the program counter is 0, every stage valid flag is clear, `halted` is 0, and every register reads 0 through the debug port.
- R2: The instruction word has five fields: opcode in bits 31:28, destination in 27:24, source A in 23:20, source B in 19:16 and immediate in 15:0. The arithmetic and logic opcodes write the destination as follows: 5 writes A+B, 6 writes A-B, 7 writes the low 32 bits of A*B, 8 writes A&B, 9 writes A|B and 10 writes ~A.
- R3: Opcode 11 writes 1 when A is less than B as signed numbers, and 0 otherwise. Opcode 12 writes 1 when A is greater than B as signed numbers, and 0 otherwise.
- R4: Opcode 1 copies A into the destination. Opcode 2 writes the sign-extended immediate.
- R5: Opcode 3 loads the data word at address A + sign-extended immediate into the destination. Opcode 4 stores B at that same address. The address wraps modulo the data memory depth.
- R6: An instruction fetched at edge c reads its sources at edge c+1, and its result reaches the register file at edge c+4. Fetches occur every second edge. A reader placed directly after a writer therefore sees the old value, and a reader placed two slots later sees the new value.
- R7: Opcode 13 branches when A is zero, opcode 14 branches when A is nonzero, and opcode 15 branches always. The target is the branch's own address plus the sign-extended immediate. The one instruction fetched behind a taken branch is discarded. An untaken branch falls through to the next address.
- R8: Opcode 0 sets `halted` when it reaches write-back. From then on the program counter, the registers and the data memory stay unchanged, and `halted` stays high until reset. Instructions fetched after the halt have no effect.
- R9: `dbg_data` shows, one clock later, the register selected by `dbg_sel`. The value is the one the register held before any write on that same edge.
- R10: While `load_en` is high, `load_data` is written at `load_addr`. It goes into data memory when `load_to_data` is 1, and into instruction memory otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe |
| load_to_data | input | 1 | Preload target: 1 selects data memory, 0 selects instruction memory |
| load_addr | input | 8 | Preload word address |
| load_data | input | 32 | Preload word |
| dbg_sel | input | 4 | Register index for the debug port |
| dbg_data | output | 32 | Registered contents of the selected register |
| halted | output | 1 | Completion flag, set by a halt at write-back |

## Verification
The assertions assume that reset is asserted before the first program runs. They also assume that the preload port stays idle while the core executes, so a preload never collides with a store in the same cycle. The bench honours this: it fills both memories completely, including every unused word, only while reset is high. Every program image contains only defined opcodes and follows the spacing rule. The one deliberate exception is a read placed directly behind its writer, which checks the old-value behaviour.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 4;
  localparam int NREG = 1 << RIDX;
  localparam int IMMW = 16;

  typedef enum logic [3:0] {
    OP_HALT  = 4'd0,
    OP_MOVE  = 4'd1,
    OP_LDI   = 4'd2,
    OP_LOAD  = 4'd3,
    OP_STORE = 4'd4,
    OP_ADD   = 4'd5,
    OP_SUB   = 4'd6,
    OP_MUL   = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_NOT   = 4'd10,
    OP_LT    = 4'd11,
    OP_GT    = 4'd12,
    OP_BZ    = 4'd13,
    OP_BNZ   = 4'd14,
    OP_JUMP  = 4'd15
  } op_e;

  function automatic logic op_writes(op_e op);
    case (op)
      OP_MOVE, OP_LDI, OP_LOAD, OP_ADD, OP_SUB, OP_MUL,
      OP_AND, OP_OR, OP_NOT, OP_LT, OP_GT: return 1'b1;
      default:                             return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction
endpackage

// File: rtl/core_ram.sv
module core_ram #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] ra_idx,
  input  logic [RIDX-1:0] rb_idx,
  output logic [XLEN-1:0] ra_val,
  output logic [XLEN-1:0] rb_val,
  input  logic [RIDX-1:0] dbg_idx,
  output logic [XLEN-1:0] dbg_val
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      dbg_val <= '0;
    end else begin
      if (we) regs[waddr] <= wdata;
      dbg_val <= regs[dbg_idx];
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (op)
      OP_MOVE: res = a;
      OP_LDI:  res = sext_imm(imm);
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      OP_LT:   res = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      OP_GT:   res = {{(XLEN-1){1'b0}}, $signed(a) > $signed(b)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import core_pkg::*;
#(
  parameter int IAW  = 8,
  parameter int DAW  = 8,
  parameter int LDAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic            load_to_data,
  input  logic [LDAW-1:0] load_addr,
  input  logic [XLEN-1:0] load_data,
  input  logic [RIDX-1:0] dbg_sel,
  output logic [XLEN-1:0] dbg_data,
  output logic            halted
);
  logic phase_q, halted_q;
  logic adv0, adv1;
  logic [IAW-1:0] pc_q;

  // fetch/decode
  logic            fd_valid;
  logic [IAW-1:0]  fd_pc;
  logic [XLEN-1:0] fd_instr;
  // decode/execute
  logic            de_valid;
  op_e             de_op;
  logic [RIDX-1:0] de_rd;
  logic [XLEN-1:0] de_a, de_b;
  logic [IMMW-1:0] de_imm;
  logic [IAW-1:0]  de_pc;
  // execute/memory
  logic            em_valid;
  op_e             em_op;
  logic [RIDX-1:0] em_rd;
  logic [XLEN-1:0] em_res, em_sdata;
  logic [DAW-1:0]  em_addr;
  // memory/write-back
  logic            mw_valid;
  op_e             mw_op;
  logic [RIDX-1:0] mw_rd;
  logic [XLEN-1:0] mw_res;

  logic [XLEN-1:0] rs_a, rs_b, alu_res, dmem_rdata, wb_data;
  logic            take;
  logic [IAW-1:0]  target;
  logic            st_we, dm_we, im_we, rf_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  assign adv0 = !phase_q && !halted_q;
  assign adv1 =  phase_q && !halted_q;

  assign take = de_valid && ((de_op == OP_JUMP) ||
                             (de_op == OP_BZ  && de_a == '0) ||
                             (de_op == OP_BNZ && de_a != '0));
  assign target = de_pc + de_imm[IAW-1:0];

  assign im_we    = load_en && !load_to_data;
  assign st_we    = adv1 && em_valid && (em_op == OP_STORE);
  assign dm_we    = (load_en && load_to_data) || st_we;
  assign dm_waddr = (load_en && load_to_data) ? load_addr[DAW-1:0] : em_addr;
  assign dm_wdata = (load_en && load_to_data) ? load_data : em_sdata;

  assign wb_data = (mw_op == OP_LOAD) ? dmem_rdata : mw_res;
  assign rf_we   = adv0 && mw_valid && op_writes(mw_op);

  core_ram #(.AW(IAW), .W(XLEN)) u_imem (
    .clk(clk), .we(im_we), .waddr(load_addr[IAW-1:0]), .wdata(load_data),
    .re(adv0), .raddr(pc_q), .rdata(fd_instr)
  );

  core_ram #(.AW(DAW), .W(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .re(adv1), .raddr(em_addr), .rdata(dmem_rdata)
  );

  core_regfile u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(mw_rd), .wdata(wb_data),
    .ra_idx(fd_instr[23:20]), .rb_idx(fd_instr[19:16]),
    .ra_val(rs_a), .rb_val(rs_b),
    .dbg_idx(dbg_sel), .dbg_val(dbg_data)
  );

  core_alu u_alu (
    .op(de_op), .a(de_a), .b(de_b), .imm(de_imm), .res(alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      halted_q <= 1'b0;
      pc_q     <= '0;
      fd_valid <= 1'b0;
      de_valid <= 1'b0;
      em_valid <= 1'b0;
      mw_valid <= 1'b0;
    end else begin
      phase_q <= !phase_q;
      if (adv0) begin
        // fetch: a taken branch in execute squashes this slot
        fd_valid <= !take;
        fd_pc    <= pc_q;
        pc_q     <= take ? target : pc_q + 1'b1;
        // execute
        em_valid <= de_valid;
        em_op    <= de_op;
        em_rd    <= de_rd;
        em_res   <= alu_res;
        em_addr  <= de_a[DAW-1:0] + de_imm[DAW-1:0];
        em_sdata <= de_b;
        // write-back: halt completes here
        if (mw_valid && mw_op == OP_HALT) halted_q <= 1'b1;
      end
      if (adv1) begin
        // decode with operand read
        de_valid <= fd_valid;
        de_op    <= op_e'(fd_instr[31:28]);
        de_rd    <= fd_instr[27:24];
        de_a     <= rs_a;
        de_b     <= rs_b;
        de_imm   <= fd_instr[15:0];
        de_pc    <= fd_pc;
        // memory
        mw_valid <= em_valid;
        mw_op    <= em_op;
        mw_rd    <= em_rd;
        mw_res   <= em_res;
      end
    end
  end

  assign halted = halted_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0 && !halted_q && !fd_valid && !de_valid && !em_valid && !mw_valid));

  assert_squash_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    (adv0 && take) |=> ##1 !de_valid);

  assert_halt_from_wb_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_q) |-> ($past(mw_valid) && $past(mw_op) == OP_HALT));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q);

  assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> $stable(pc_q));

  assert_no_store_halted_R8: assert property (@(posedge clk) disable iff (rst)
    $past(halted_q) |-> !st_we);
endmodule

// File: tb/pipe_core_bench.sv
`timescale 1ns/1ps
module pipe_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_to_data = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [3:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  logic        halted;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] prog [256];
  // reference model output: scheduled register writes and the halt edge
  int          ev_cyc [512];
  int          ev_reg [512];
  logic [31:0] ev_val [512];
  int          nev;
  int          halt_cyc;

  always #2.5 clk = ~clk;

  pipe_core u_pipe_core (
    .clk(clk), .rst(rst), .load_en(load_en), .load_to_data(load_to_data),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int op, int rd, int a, int b, int imm);
    return {op[3:0], rd[3:0], a[3:0], b[3:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] dinit(int i);
    return (i == 25) ? 32'hCAFE0001 : 32'(i * 3 + 256);
  endfunction

  localparam logic [31:0] NOP = 32'h9FFF0000; // R15 := R15 | R15

  // R10: preload both memories under reset
  task automatic preload();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_to_data = 1'b0; load_addr = 8'(i); load_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_to_data = 1'b1; load_addr = 8'(i); load_data = dinit(i);
      @(negedge clk);
    end
    load_en = 1'b0;
    dbg_sel = 4'd3;
    @(negedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 halted in reset", 32'(halted), 32'd0);
    check(dbg_data == 32'd0, "R1 register in reset", dbg_data, 32'd0);
  endtask

  // Architectural model with the documented stage timing
  task automatic run_model();
    logic [31:0] dv [16];
    logic [31:0] dm [256];
    int c = 1, pc = 0, q = 0;
    nev = 0;
    halt_cyc = 1000000;
    for (int i = 0; i < 16; i++) dv[i] = '0;
    for (int i = 0; i < 256; i++) dm[i] = dinit(i);
    for (int step = 0; step < 2000; step++) begin
      logic [31:0] w, a, b, r, sx;
      int op, rd, addr;
      bit wr, tk;
      w  = prog[pc];
      op = int'(w[31:28]); rd = int'(w[27:24]);
      while (q < nev && ev_cyc[q] <= c) begin dv[ev_reg[q]] = ev_val[q]; q++; end
      a  = dv[w[23:20]]; b = dv[w[19:16]];
      sx = {{16{w[15]}}, w[15:0]};
      addr = int'(8'(a + sx));
      wr = 1; tk = 0; r = '0;
      case (op)
        0: begin halt_cyc = c + 4; break; end
        1: r = a;
        2: r = sx;
        3: r = dm[addr];
        4: begin dm[addr] = b; wr = 0; end
        5: r = a + b;
        6: r = a - b;
        7: r = a * b;
        8: r = a & b;
        9: r = a | b;
        10: r = ~a;
        11: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        12: r = ($signed(a) > $signed(b)) ? 32'd1 : 32'd0;
        13: begin wr = 0; tk = (a == 0); end
        14: begin wr = 0; tk = (a != 0); end
        default: begin wr = 0; tk = 1; end
      endcase
      if (wr) begin ev_cyc[nev] = c + 4; ev_reg[nev] = rd; ev_val[nev] = r; nev++; end
      if (tk) begin pc = (pc + int'(sx)) & 255; c += 4; end
      else    begin pc = (pc + 1) & 255;        c += 2; end
    end
  endtask

  // Release reset and compare the core to the model on every clock
  task automatic run_compare();
    logic [31:0] mregs [16];
    logic [31:0] prev [16];
    int p = 0;
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    dbg_sel = 4'd0;
    rst = 1'b0;
    for (int n = 1; n <= halt_cyc + 12; n++) begin
      logic [3:0] sel_used;
      for (int i = 0; i < 16; i++) prev[i] = mregs[i];
      sel_used = dbg_sel;
      @(posedge clk);
      @(negedge clk);
      while (p < nev && ev_cyc[p] <= n && ev_cyc[p] < halt_cyc) begin
        mregs[ev_reg[p]] = ev_val[p]; p++;
      end
      check(halted == (n >= halt_cyc), "R8 halted timing", 32'(halted), 32'(n >= halt_cyc));
      check(dbg_data == prev[sel_used], "R9 debug vs model", dbg_data, prev[sel_used]);
      dbg_sel = 4'(n * 5);
    end
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_sel = 4'(idx);
    @(posedge clk);
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic expect_reg(input int idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    read_reg(idx, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    // ---------- program A: arithmetic, compares, memory, timing, halt ----------
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0]  = enc(2, 1, 0, 0, 7);
    prog[1]  = enc(2, 2, 0, 0, -3);
    prog[2]  = NOP;
    prog[3]  = enc(5, 3, 1, 2, 0);
    prog[4]  = enc(6, 4, 1, 2, 0);
    prog[5]  = enc(7, 5, 1, 2, 0);
    prog[6]  = enc(8, 6, 1, 2, 0);
    prog[7]  = enc(9, 7, 1, 2, 0);
    prog[8]  = enc(10, 8, 1, 0, 0);
    prog[9]  = enc(11, 9, 2, 1, 0);
    prog[10] = enc(12, 10, 2, 1, 0);
    prog[11] = enc(1, 11, 2, 0, 0);
    prog[12] = enc(2, 12, 0, 0, 20);
    prog[13] = enc(5, 13, 12, 1, 0);   // directly behind writer of R12
    prog[14] = enc(4, 0, 12, 4, -2);   // mem[18] := R4
    prog[15] = enc(3, 14, 12, 0, 5);   // R14 := mem[25]
    prog[16] = NOP;
    prog[17] = enc(3, 0, 12, 0, -2);   // R0 := mem[18]
    prog[18] = enc(0, 0, 0, 0, 0);
    prog[19] = enc(2, 1, 0, 0, 99);    // behind halt
    prog[20] = enc(4, 0, 12, 1, 0);
    preload();
    run_model();
    run_compare();
    expect_reg(3,  32'd4,        "R2 ADD");
    expect_reg(4,  32'd10,       "R2 SUB");
    expect_reg(5,  32'hFFFFFFEB, "R2 MUL");
    expect_reg(6,  32'd5,        "R2 AND");
    expect_reg(7,  32'hFFFFFFFF, "R2 OR");
    expect_reg(8,  32'hFFFFFFF8, "R2 NOT");
    expect_reg(9,  32'd1,        "R3 signed less");
    expect_reg(10, 32'd0,        "R3 signed greater");
    expect_reg(11, 32'hFFFFFFFD, "R4 MOVE");
    expect_reg(2,  32'hFFFFFFFD, "R4 immediate sign extension");
    expect_reg(13, 32'd7,        "R6 adjacent reader sees old value");
    expect_reg(14, 32'hCAFE0001, "R10 preloaded data word via load");
    expect_reg(0,  32'd10,       "R5 store then load");
    expect_reg(1,  32'd7,        "R8 instruction behind halt ignored");
    check(halted == 1'b1, "R8 halted sticky", 32'(halted), 32'd1);

    // ---------- program B: branches and squash ----------
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0]  = enc(2, 1, 0, 0, 0);
    prog[1]  = enc(2, 2, 0, 0, 5);
    prog[2]  = enc(2, 3, 0, 0, 0);
    prog[3]  = enc(2, 4, 0, 0, 1);
    prog[4]  = NOP;
    prog[5]  = enc(5, 3, 3, 4, 0);
    prog[6]  = enc(6, 2, 2, 4, 0);
    prog[7]  = NOP;
    prog[8]  = enc(14, 0, 2, 0, -3);   // loop while R2 != 0
    prog[9]  = enc(5, 6, 6, 4, 0);     // squashed when taken
    prog[10] = enc(13, 0, 1, 0, 3);    // taken to 13
    prog[11] = enc(2, 7, 0, 0, 77);
    prog[12] = enc(2, 8, 0, 0, 88);
    prog[13] = enc(15, 0, 0, 0, 2);    // to 15
    prog[14] = enc(2, 9, 0, 0, 99);
    prog[15] = enc(13, 0, 4, 0, 5);    // not taken
    prog[16] = enc(2, 10, 0, 0, 42);
    prog[17] = enc(0, 0, 0, 0, 0);
    preload();
    run_model();
    run_compare();
    expect_reg(3,  32'd5,  "R7 loop count");
    expect_reg(2,  32'd0,  "R7 loop exit");
    expect_reg(6,  32'd1,  "R7 squash behind taken branch");
    expect_reg(7,  32'd0,  "R7 zero-branch squash");
    expect_reg(8,  32'd0,  "R7 skipped instruction");
    expect_reg(9,  32'd0,  "R7 jump squash");
    expect_reg(10, 32'd42, "R7 untaken fall-through");

    done = 1;
    summary();
    $finish;
  end
endmodule